// File: doc/BRIEF.md
# Nibble-Serial Accumulator Datapath

This block is the arithmetic core of a small 16-bit processor. It holds four general-purpose accumulators and a single 4-bit adder. A 16-bit operation walks through both operands one nibble per clock, least significant nibble first. The carry out of each nibble is held in a register and feeds the next nibble. Each accumulator is stored as four interleaved slices. Slice j holds word bits j, j+4, j+8 and j+12, so one shift of every slice advances the whole word by one nibble. Each result nibble enters at the top of the destination while the source rotates back to where it started.

A controller outside the block drives source and destination selects, a 3-bit operation code, an external word for loads, and a one-cycle start strobe. The block reports the destination word, a carry flag and a zero flag, and raises done for one cycle when the operation ends. The sequencer has four states:
- IDLE waits for start. Start moves it to RUN.
- RUN spends four clocks on the four nibbles. After the last nibble it moves to FIX for subtract-and-shift, and to FIN for every other operation.
- FIX spends one clock shifting the stored difference left by one bit. It moves to FIN.
- FIN asserts done for one cycle and returns to IDLE.

Top module: `nsd_top`

## Requirements
- R1: After reset all four accumulators hold 0. After reset, done, carry and zero are 0 and result is 0.
- R2: Start is taken only in IDLE. Done is high for exactly one cycle. Done rises four clocks after the clock edge that takes start, or five clocks for subtract-and-shift.
- R3: Op code 0 (add) writes (dst + src) mod 2^16 into the destination. Carry is the carry out of bit 15.
- R4: Op code 1 (subtract) writes (dst − src) mod 2^16 into the destination. Carry is 1 when there is no borrow, which means dst ≥ src unsigned.
- R5: Op code 2 (compare) leaves the destination unchanged. Zero is 1 exactly when dst equals src. Carry is set as for subtract.
- R6: Op code 3 (subtract-and-shift) computes the subtract result d and its no-borrow bit n. It writes {d[14:0], n} into the destination. Carry becomes d[15], and zero is set when the written word is 0.
- R7: An op code with bit 2 set (load) writes ext_word into the destination. Carry becomes 0, and zero is set when ext_word is 0.
- R8: For add, subtract and compare, zero is 1 exactly when the 16-bit sum or difference is 0. Both flags change only at the end of an operation and keep their value until the next operation ends.
- R9: Only the destination accumulator can change. The source and the other accumulators keep their values. When source equals destination, both operands are the old value. While IDLE with no start, result does not change.
- R10: Start, op, selects and ext_word are ignored while an operation is in progress. The operation that is running completes unchanged.
- R11: Result always shows the destination accumulator of the most recently accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken in IDLE only) |
| op | input | 3 | 0 add, 1 subtract, 2 compare, 3 subtract-and-shift, bit 2 set = load |
| src_sel | input | 2 | Source accumulator index |
| dst_sel | input | 2 | Destination accumulator index |
| ext_word | input | 16 | Word written by a load |
| result | output | 16 | Current destination accumulator word |
| carry | output | 1 | Carry / no-borrow flag |
| zero | output | 1 | Zero / equality flag |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
Two situations are hard to reach from the ports.

The first is the ripple of a carry or borrow through all four nibbles. It needs operand pairs such as 0xFFFF plus 0x0001, or 0x0000 minus 0x0001, where each registered carry decides the next nibble. The bench sweeps every ordered pair from a set of boundary and mixed-pattern words. It runs each pair through every arithmetic operation, with source and destination indices rotating so that aliased selects also occur.

The second is a start that arrives mid-operation. The bench raises start with a different operation, destination and word during RUN. It then checks that the original result, latency and untouched accumulators are unchanged.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX, ST_FIN} nsd_state_t;

    localparam logic [2:0] OP_ADD   = 3'd0;
    localparam logic [2:0] OP_SUB   = 3'd1;
    localparam logic [2:0] OP_CMP   = 3'd2;
    localparam logic [2:0] OP_SUBSL = 3'd3;

    function automatic logic op_is_load(input logic [2:0] o);
        return o[2];
    endfunction

    function automatic logic op_is_subtract(input logic [2:0] o);
        return !o[2] && (o[1:0] != 2'd0);
    endfunction
endpackage

// File: rtl/nsd_ilv_reg.sv
module nsd_ilv_reg #(
    parameter int NIB_W = 4,
    parameter int NIBS  = 4,
    localparam int W    = NIB_W * NIBS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [NIB_W-1:0] nib_in,
    input  logic             par_en,
    input  logic [W-1:0]     par_word,
    output logic [NIB_W-1:0] low_nib,
    output logic [W-1:0]     word
);
    // Slice j holds word bits j, j+NIB_W, j+2*NIB_W, ...
    for (genvar j = 0; j < NIB_W; j++) begin : g_slice
        logic [NIBS-1:0] slice_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slice_q <= '0;
            end else if (par_en) begin
                for (int k = 0; k < NIBS; k++) slice_q[k] <= par_word[k*NIB_W+j];
            end else if (shift_en) begin
                slice_q <= {nib_in[j], slice_q[NIBS-1:1]};
            end
        end

        assign low_nib[j] = slice_q[0];
        for (genvar k = 0; k < NIBS; k++) begin : g_bit
            assign word[k*NIB_W+j] = slice_q[k];
        end
    end
endmodule

// File: rtl/nsd_nib_add.sv
module nsd_nib_add #(
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0] a,
    input  logic [NIB_W-1:0] b,
    input  logic             inv,
    input  logic             cin,
    output logic [NIB_W-1:0] sum,
    output logic             cout
);
    logic [NIB_W-1:0] a_eff;
    assign a_eff = inv ? ~a : a;
    assign {cout, sum} = {1'b0, b} + {1'b0, a_eff} + {{NIB_W{1'b0}}, cin};
endmodule

// File: rtl/nsd_seq.sv
module nsd_seq
    import nsd_pkg::*;
#(
    parameter int NIBS = 4,
    localparam int CW  = (NIBS > 1) ? $clog2(NIBS) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] op_in,
    output nsd_state_t state,
    output logic [2:0] op_q,
    output logic       accept,
    output logic       last_nib
);
    nsd_state_t      state_d;
    logic [CW-1:0]   cnt_q;

    assign accept   = (state == ST_IDLE) && start;
    assign last_nib = (state == ST_RUN) && (cnt_q == CW'(NIBS - 1));

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last_nib) state_d = (op_q == OP_SUBSL) ? ST_FIX : ST_FIN;
            ST_FIX:  state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
            op_q  <= OP_ADD;
        end else begin
            state <= state_d;
            if (accept) begin
                op_q  <= op_in;
                cnt_q <= '0;
            end else if (state == ST_RUN) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2
    seq_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == ST_RUN) && (cnt_q == '0));
    // R2
    seq_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && !last_nib) |=> (state == ST_RUN));
endmodule

// File: rtl/nsd_top.sv
module nsd_top
    import nsd_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int NIBS  = 4,
    parameter int NACC  = 4,
    localparam int W    = NIB_W * NIBS,
    localparam int SW   = $clog2(NACC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [SW-1:0] src_sel,
    input  logic [SW-1:0] dst_sel,
    input  logic [W-1:0]  ext_word,
    output logic [W-1:0]  result,
    output logic          carry,
    output logic          zero,
    output logic          done
);
    nsd_state_t       state;
    logic [2:0]       op_q;
    logic             accept, last_nib, run, fix;
    logic [SW-1:0]    src_q, dst_q;
    logic [W-1:0]     ext_q;
    logic             carry_q, zacc_q, carry_f, zero_f;
    logic [NIB_W-1:0] lo [NACC];
    logic [W-1:0]     wd [NACC];
    logic [NIB_W-1:0] a_nib, b_nib, sum;
    logic             cout, inv, is_load;
    logic [W-1:0]     dst_w;

    nsd_seq #(.NIBS(NIBS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op),
        .state(state), .op_q(op_q), .accept(accept), .last_nib(last_nib)
    );

    assign run     = (state == ST_RUN);
    assign fix     = (state == ST_FIX);
    assign is_load = op_is_load(op_q);
    assign inv     = op_is_subtract(op_q);
    assign dst_w   = wd[dst_q];
    assign a_nib   = is_load ? ext_q[NIB_W-1:0] : lo[src_q];
    assign b_nib   = is_load ? '0 : lo[dst_q];

    nsd_nib_add #(.NIB_W(NIB_W)) u_add (
        .a(a_nib), .b(b_nib), .inv(inv), .cin(carry_q), .sum(sum), .cout(cout)
    );

    for (genvar i = 0; i < NACC; i++) begin : g_acc
        logic             is_dst, sh_en, pe;
        logic [NIB_W-1:0] nin;
        assign is_dst = (dst_q == SW'(i));
        assign sh_en  = run && (is_dst || (src_q == SW'(i)));
        assign nin    = (is_dst && (op_q != OP_CMP)) ? sum : lo[i];
        assign pe     = fix && is_dst;

        nsd_ilv_reg #(.NIB_W(NIB_W), .NIBS(NIBS)) u_acc (
            .clk(clk), .rst_n(rst_n), .shift_en(sh_en), .nib_in(nin),
            .par_en(pe), .par_word({dst_w[W-2:0], carry_q}),
            .low_nib(lo[i]), .word(wd[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            ext_q   <= '0;
            carry_q <= 1'b0;
            zacc_q  <= 1'b0;
            carry_f <= 1'b0;
            zero_f  <= 1'b0;
        end else if (accept) begin
            src_q   <= src_sel;
            dst_q   <= dst_sel;
            ext_q   <= ext_word;
            carry_q <= op_is_subtract(op);
            zacc_q  <= 1'b1;
        end else if (run) begin
            carry_q <= cout;
            zacc_q  <= zacc_q && (sum == '0);
            ext_q   <= ext_q >> NIB_W;
            if (last_nib && (op_q != OP_SUBSL)) begin
                carry_f <= cout;
                zero_f  <= zacc_q && (sum == '0);
            end
        end else if (fix) begin
            carry_f <= dst_w[W-1];
            zero_f  <= ({dst_w[W-2:0], carry_q} == '0);
        end
    end

    assign result = dst_w;
    assign carry  = carry_f;
    assign zero   = zero_f;
    assign done   = (state == ST_FIN);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && start) |=> ($stable(dst_q) && $stable(src_q) && $stable(op_q)));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !start) |=> $stable(result));
    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> ($stable(carry) && $stable(zero)));
endmodule

// File: tb/nsd_top_tb.sv
module nsd_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  src_sel = '0, dst_sel = '0;
    logic [15:0] ext_word = '0;
    logic [15:0] result;
    logic        carry, zero, done;

    int n_chk = 0, n_err = 0;
    logic [15:0] m [4];

    always #5 clk = ~clk;

    nsd_top u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src_sel(src_sel),
        .dst_sel(dst_sel), .ext_word(ext_word), .result(result),
        .carry(carry), .zero(zero), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected destination word and flags, from the requirements only.
    task automatic model(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] x, output logic [15:0] nd,
                         output logic c, output logic z);
        logic [16:0] t;
        if (o[2]) begin nd = x; c = 1'b0; z = (x == 0); end   // R7
        else if (o == 3'd0) begin t = {1'b0, b} + {1'b0, a}; nd = t[15:0]; c = t[16]; z = (nd == 0); end
        else begin
            t = {1'b0, b} + {1'b0, ~a} + 17'd1;
            c = t[16];
            if (o == 3'd2) begin nd = b; z = (t[15:0] == 0); end
            else if (o == 3'd1) begin nd = t[15:0]; z = (nd == 0); end
            else begin nd = {t[14:0], t[16]}; c = t[15]; z = (nd == 0); end
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic [1:0] s, input logic [1:0] d,
                          input logic [15:0] x, output int lat);
        @(negedge clk);
        op = o; src_sel = s; dst_sel = d; ext_word = x; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin @(negedge clk); lat++; end
    endtask

    task automatic exec(input logic [2:0] o, input logic [1:0] s, input logic [1:0] d,
                        input logic [15:0] x, input string tag);
        int lat;
        logic [15:0] nd; logic c, z;
        model(o, m[s], m[d], x, nd, c, z);
        run_op(o, s, d, x, lat);
        // R2
        chk(lat == ((o == 3'd3) ? 6 : 5), {tag, " R2 latency"}, lat, (o == 3'd3) ? 6 : 5);
        chk(result == nd, {tag, " result"}, result, nd);
        chk(carry == c, {tag, " carry"}, carry, c);
        chk(zero == z, {tag, " zero"}, zero, z);
        m[d] = nd;
        @(negedge clk);
        chk(!done, {tag, " R2 done one cycle"}, done, 0);
    endtask

    task automatic verify_all(input string tag);
        int lat;
        for (int i = 0; i < 4; i++) begin
            run_op(3'd2, 2'(i), 2'(i), 16'h0, lat);
            // R9 R11 readback by compare with itself
            chk(result == m[i], {tag, " R9 R11 acc readback"}, result, m[i]);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        // R1
        chk(result == 0 && !done && !carry && !zero, "R1 reset outputs",
            {result, 13'b0, done, carry, zero}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        verify_all("R1");

        begin
            logic [15:0] vals [8];
            vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
            vals[4] = 16'hFFFF; vals[5] = 16'h1234; vals[6] = 16'h0F0F; vals[7] = 16'hA5C3;
            for (int o = 0; o < 4; o++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        logic [1:0] s, d;
                        s = 2'(i);
                        d = 2'(j + o);
                        exec(3'd4, 2'd0, s, vals[i], "R7 load src");
                        exec(3'd7, 2'd1, d, vals[j], "R7 load dst");
                        case (o)
                            0: exec(3'(o), s, d, 16'h0, "R3 add");
                            1: exec(3'(o), s, d, 16'h0, "R4 sub");
                            2: exec(3'(o), s, d, 16'h0, "R5 R8 cmp");
                            default: exec(3'(o), s, d, 16'h0, "R6 subsl");
                        endcase
                        if (i == j) verify_all("R9");
                    end
                end
            end
        end

        // R10: start raised during RUN with another op, destination and word
        begin
            int lat;
            logic [15:0] nd; logic c, z;
            exec(3'd4, 2'd0, 2'd0, 16'h00FF, "R7 setup");
            exec(3'd4, 2'd0, 2'd1, 16'hFF01, "R7 setup");
            model(3'd0, m[0], m[1], 16'h0, nd, c, z);
            @(negedge clk);
            op = 3'd0; src_sel = 2'd0; dst_sel = 2'd1; start = 1'b1;
            @(negedge clk);
            op = 3'd4; dst_sel = 2'd2; ext_word = 16'hBEEF;
            lat = 1;
            @(negedge clk); lat++;
            @(negedge clk); lat++;
            start = 1'b0;
            while (!done && lat < 20) begin @(negedge clk); lat++; end
            chk(lat == 5, "R10 latency unchanged", lat, 5);
            chk(result == nd, "R10 result of running op", result, nd);
            chk(carry == c, "R10 carry", carry, c);
            m[1] = nd;
            @(negedge clk);
            verify_all("R10");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule